// File: doc/BRIEF.md
# Serial Control and Status Register Slave

This block is the slave end of a four-wire serial link. On each transfer it takes in a 16-bit control word and sends back a 16-bit status word. It runs on a system clock. The chip select, serial clock and serial data input are brought into that clock domain through a synchronizer, and edges are found there, so the serial clock must be several times slower than the system clock.

When chip select falls, the block copies one of four parallel diagnostic words into its shift register and starts driving the serial output. When chip select rises, the received word is applied, but only if exactly sixteen bits arrived. A frame has three fields:
- bits [1:0] form an address. It picks the 8-bit control register that bits [15:8] are written to. It also picks the diagnostic word that the next transfer returns.
- bits [7:2] form a shared 6-bit control field, written on every accepted frame.
- bits [15:8] are the addressable data.

With chip select high, the data output is released through its enable, so several slaves can share the line, each with its own chip select. Frames longer than sixteen bits pass through to the serial output unchanged, which allows daisy-chaining.

Top module: `spi_cs_regif`

## Requirements
- R1: After the asynchronous reset, all four control registers and the shared field read zero, the output enable is low, and the status address pointer is zero, so the first transfer returns diagnostic word 0.
- R2: While chip select is high, the output enable is low and the serial data output is held at 0.
- R3: Each serial pin change takes effect at the third rising system clock edge after it is applied. On a chip select fall, the diagnostic word selected by the pointer is copied and its bit 15 is driven, with the enable high. Changes to the diagnostic inputs later in the frame do not affect the returned word.
- R4: The serial data input is sampled on falling serial clock edges, most significant bit first.
- R5: The serial data output changes only on rising serial clock edges, and presents the shift register's top bit at each one.
- R6: On a chip select rise after exactly 16 falling serial clock edges, bits [15:8] are written to the control register numbered by bits [1:0]. The other three control registers keep their values.
- R7: On every accepted frame, bits [7:2] are written to the shared control field, whatever the address.
- R8: A transfer returns the diagnostic word whose index equals bits [1:0] of the last accepted frame. Word i sits on diagnostic input bits [16*i+15:16*i].
- R9: A frame ending after any number of falling serial clock edges other than 16 is discarded. The control registers, the shared field and the pointer stay unchanged.
- R10: A bit sampled at falling serial clock edge k appears on the serial data output after rising edge k+16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low power-on reset |
| spi_csn_i | input | 1 | Chip select, active low |
| spi_sck_i | input | 1 | Serial clock, idles low |
| spi_di_i | input | 1 | Serial data in |
| spi_do_o | output | 1 | Serial data out |
| spi_do_oe_o | output | 1 | Output enable for the serial data out driver |
| diag_i | input | 64 | Four 16-bit diagnostic status words |
| ctrl_reg_o | output | 32 | Four 8-bit addressable control registers, register i at [8*i+7:8*i] |
| ctrl_com_o | output | 6 | Shared control field |

## Verification
A corrupted shift register or a broken edge detector shows up on the serial output within one serial clock period. The bench compares a per-clock model against the outputs, so the failing system clock cycle is identified. A wrong bit counter or address pointer stays hidden until the frame closes. It then shows as a control register written or skipped in error, and one transfer later as the wrong diagnostic word being returned. Short, long and daisy-chained frames probe the counter, and transfers to every address probe the pointer.

// File: rtl/spi_cs_pkg.sv
package spi_cs_pkg;
  localparam int FRAME_W = 16;
  localparam int ADDR_W  = 2;
  localparam int N_REG   = 1 << ADDR_W;
  localparam int DATA_W  = 8;
  localparam int COM_W   = FRAME_W - DATA_W - ADDR_W;
  localparam int CNT_W   = $clog2(FRAME_W) + 2;

  typedef struct packed {
    logic [DATA_W-1:0] data;
    logic [COM_W-1:0]  com;
    logic [ADDR_W-1:0] addr;
  } frame_t;
endpackage

// File: rtl/spi_cs_sync.sv
module spi_cs_sync #(
  parameter int STAGES = 2,
  parameter int W = 3,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o,
  output logic [W-1:0] rise_o,
  output logic [W-1:0] fall_o
);
  logic [W-1:0] stg [STAGES];
  logic [W-1:0] prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stg[0] <= RST_VAL;
    else         stg[0] <= d_i;
  end

  for (genvar i = 1; i < STAGES; i++) begin : g_stg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stg[i] <= RST_VAL;
      else         stg[i] <= stg[i-1];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= RST_VAL;
    else         prev_q <= stg[STAGES-1];
  end

  assign q_o    = stg[STAGES-1];
  assign rise_o = q_o & ~prev_q;
  assign fall_o = ~q_o & prev_q;
endmodule

// File: rtl/spi_cs_shift.sv
module spi_cs_shift
  import spi_cs_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               load_i,
  input  logic [FRAME_W-1:0] load_word_i,
  input  logic               active_i,
  input  logic               sck_rise_i,
  input  logic               sck_fall_i,
  input  logic               di_i,
  output logic               do_o,
  output logic [FRAME_W-1:0] word_o,
  output logic [CNT_W-1:0]   cnt_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [FRAME_W-1:0] sh_q;
  logic               do_q;
  logic [CNT_W-1:0]   cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q  <= '0;
      do_q  <= 1'b0;
      cnt_q <= '0;
    end else if (load_i) begin
      sh_q  <= load_word_i;
      do_q  <= load_word_i[FRAME_W-1];
      cnt_q <= '0;
    end else if (active_i) begin
      if (sck_rise_i) do_q <= sh_q[FRAME_W-1];
      if (sck_fall_i) begin
        sh_q <= {sh_q[FRAME_W-2:0], di_i};
        if (cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign do_o   = do_q;
  assign word_o = sh_q;
  assign cnt_o  = cnt_q;

  a_r3_snapshot_msb: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> do_q == $past(load_word_i[FRAME_W-1]));
  a_r5_do_holds_on_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sck_fall_i && !load_i) |=> $stable(do_q));
  a_r4_shift_on_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sck_fall_i && active_i && !load_i) |=> sh_q[0] == $past(di_i));
endmodule

// File: rtl/spi_cs_regs.sv
module spi_cs_regs
  import spi_cs_pkg::*;
(
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      commit_i,
  input  frame_t                    frame_i,
  output logic [N_REG*DATA_W-1:0]   ctrl_o,
  output logic [COM_W-1:0]          com_o,
  output logic [ADDR_W-1:0]         ptr_o
);
  for (genvar i = 0; i < N_REG; i++) begin : g_reg
    logic [DATA_W-1:0] r_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) r_q <= '0;
      else if (commit_i && frame_i.addr == ADDR_W'(i)) r_q <= frame_i.data;
    end
    assign ctrl_o[i*DATA_W +: DATA_W] = r_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      com_o <= '0;
      ptr_o <= '0;
    end else if (commit_i) begin
      com_o <= frame_i.com;
      ptr_o <= frame_i.addr;
    end
  end

  a_r8_ptr_follows_addr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_i |=> ptr_o == $past(frame_i.addr));
  a_r9_ptr_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !commit_i |=> $stable(ptr_o));
endmodule

// File: rtl/spi_cs_regif.sv
module spi_cs_regif
  import spi_cs_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    spi_csn_i,
  input  logic                    spi_sck_i,
  input  logic                    spi_di_i,
  output logic                    spi_do_o,
  output logic                    spi_do_oe_o,
  input  logic [N_REG*FRAME_W-1:0] diag_i,
  output logic [N_REG*DATA_W-1:0]  ctrl_reg_o,
  output logic [COM_W-1:0]         ctrl_com_o
);
  logic [2:0] pin_q, pin_rise, pin_fall;
  logic [ADDR_W-1:0]  ptr;
  logic [FRAME_W-1:0] word;
  logic [CNT_W-1:0]   cnt;
  logic               do_bit, oe_q, commit;
  logic               csn_fall, csn_rise;

  spi_cs_sync #(.STAGES(SYNC_STAGES), .W(3), .RST_VAL(3'b100)) u_sync (
    .clk_i, .rst_ni,
    .d_i   ({spi_csn_i, spi_sck_i, spi_di_i}),
    .q_o   (pin_q),
    .rise_o(pin_rise),
    .fall_o(pin_fall)
  );

  assign csn_fall = pin_fall[2];
  assign csn_rise = pin_rise[2];
  assign commit   = csn_rise && (cnt == CNT_W'(FRAME_W));

  spi_cs_shift u_shift (
    .clk_i, .rst_ni,
    .load_i     (csn_fall),
    .load_word_i(diag_i[ptr*FRAME_W +: FRAME_W]),
    .active_i   (~pin_q[2]),
    .sck_rise_i (pin_rise[1]),
    .sck_fall_i (pin_fall[1]),
    .di_i       (pin_q[0]),
    .do_o       (do_bit),
    .word_o     (word),
    .cnt_o      (cnt)
  );

  spi_cs_regs u_regs (
    .clk_i, .rst_ni,
    .commit_i(commit),
    .frame_i (frame_t'(word)),
    .ctrl_o  (ctrl_reg_o),
    .com_o   (ctrl_com_o),
    .ptr_o   (ptr)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       oe_q <= 1'b0;
    else if (csn_fall) oe_q <= 1'b1;
    else if (csn_rise) oe_q <= 1'b0;
  end

  assign spi_do_oe_o = oe_q;
  assign spi_do_o    = do_bit & oe_q;

  a_r3_drive_on_select: assert property (@(posedge clk_i) disable iff (!rst_ni)
    csn_fall |=> spi_do_oe_o);
  a_r2_release_on_deselect: assert property (@(posedge clk_i) disable iff (!rst_ni)
    csn_rise |=> !spi_do_oe_o);
  a_r6_ctrl_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !commit |=> $stable(ctrl_reg_o) && $stable(ctrl_com_o));
  a_r9_discard_odd_frame: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (csn_rise && cnt != CNT_W'(FRAME_W)) |=> $stable(ctrl_reg_o));
endmodule

// File: tb/spi_cs_regif_bench.sv
module spi_cs_regif_bench;
  localparam int HP = 6;

  logic clk = 0, rst_n = 0;
  logic csn = 1, sck = 0, di = 0;
  logic do_w, oe_w;
  logic [63:0] diag = 64'h0;
  logic [31:0] ctrl_w;
  logic [5:0]  com_w;
  int tot = 0, bad = 0, cyc = 0;
  bit done = 0;

  logic [7:0] e_ctrl [4];
  logic [5:0] e_com;
  int         e_ptr;

  logic [2:0]  h1 = 3'b100, h2 = 3'b100, h3 = 3'b100;
  logic [15:0] m_sh;
  logic [7:0]  m_ctrl [4];
  logic [5:0]  m_com;
  int          m_ptr, m_cnt;
  logic        m_do, m_oe;

  always #10 clk = ~clk;

  spi_cs_regif u_spi_cs_regif (
    .clk_i(clk), .rst_ni(rst_n),
    .spi_csn_i(csn), .spi_sck_i(sck), .spi_di_i(di),
    .spi_do_o(do_w), .spi_do_oe_o(oe_w),
    .diag_i(diag), .ctrl_reg_o(ctrl_w), .ctrl_com_o(com_w)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    tot++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  // behavioural reference, pins seen with a three-edge delay
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      h1 = 3'b100; h2 = 3'b100; h3 = 3'b100;
      for (int i = 0; i < 4; i++) m_ctrl[i] = 0;
      m_com = 0; m_ptr = 0; m_cnt = 0; m_do = 0; m_oe = 0; m_sh = 0;
    end else begin
      if (h3[2] && !h2[2]) begin
        m_sh = diag[m_ptr*16 +: 16]; m_do = m_sh[15]; m_cnt = 0; m_oe = 1;
      end else if (!h3[2] && h2[2]) begin
        if (m_cnt == 16) begin
          m_ctrl[m_sh[1:0]] = m_sh[15:8]; m_com = m_sh[7:2]; m_ptr = m_sh[1:0];
        end
        m_oe = 0;
      end else if (!h2[2]) begin
        if (!h3[1] && h2[1]) m_do = m_sh[15];
        if (h3[1] && !h2[1]) begin
          m_sh = {m_sh[14:0], h2[0]};
          if (m_cnt < 63) m_cnt++;
        end
      end
      h3 = h2; h2 = h1; h1 = {csn, sck, di};
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(oe_w === m_oe, "R3 model oe", oe_w, m_oe);
      chk(do_w === (m_oe & m_do), "R5 model do", do_w, m_oe & m_do);
      for (int i = 0; i < 4; i++)
        chk(ctrl_w[i*8 +: 8] === m_ctrl[i], "R6 model ctrl", ctrl_w[i*8 +: 8], m_ctrl[i]);
      chk(com_w === m_com, "R7 model com", com_w, m_com);
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      done = 1;
      bad++; tot++;
      $display("FAIL watchdog act=%0d exp=0", cyc);
      $display("  test done: total=%0d bad=%0d", tot, bad);
      $finish;
    end
  end

  task automatic xfer(input int n, input logic [63:0] tx, output logic [63:0] rx, input bit mid);
    rx = 0;
    @(negedge clk) csn = 0;
    repeat (HP) @(negedge clk);
    for (int b = n - 1; b >= 0; b--) begin
      sck = 1; di = tx[b];
      repeat (HP) @(negedge clk);
      rx[b] = do_w;
      if (mid && b == n - 4) diag = ~diag;
      sck = 0;
      repeat (HP) @(negedge clk);
    end
    csn = 1;
    repeat (HP + 2) @(negedge clk);
  endtask

  task automatic frame16(input logic [7:0] d, input logic [5:0] c, input int a);
    logic [63:0] rx;
    logic [15:0] expw;
    expw = diag[e_ptr*16 +: 16];
    xfer(16, {48'h0, d, c, a[1:0]}, rx, 0);
    chk(rx[15:0] === expw, "R8 returned status", rx[15:0], expw);
    e_ctrl[a] = d; e_com = c; e_ptr = a;
    for (int i = 0; i < 4; i++)
      chk(ctrl_w[i*8 +: 8] === e_ctrl[i], "R6 ctrl after commit", ctrl_w[i*8 +: 8], e_ctrl[i]);
    chk(com_w === e_com, "R7 shared field", com_w, e_com);
    chk(!oe_w && !do_w, "R2 idle release", {oe_w, do_w}, 0);
  endtask

  task automatic expect_unchanged(input string tag);
    for (int i = 0; i < 4; i++)
      chk(ctrl_w[i*8 +: 8] === e_ctrl[i], tag, ctrl_w[i*8 +: 8], e_ctrl[i]);
    chk(com_w === e_com, tag, com_w, e_com);
  endtask

  initial begin
    logic [63:0] rx;
    logic [15:0] expw;
    for (int i = 0; i < 4; i++) e_ctrl[i] = 0;
    e_com = 0; e_ptr = 0;
    diag = {16'h8E31, 16'h4C7A, 16'hB2D5, 16'h19F6};
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    // R1 reset state
    chk(ctrl_w === 0 && com_w === 0, "R1 reset ctrl", {com_w, ctrl_w}, 0);
    chk(!oe_w && !do_w, "R1 R2 reset idle", {oe_w, do_w}, 0);

    frame16(8'h3C, 6'h15, 2);   // R1: first frame returns word 0
    frame16(8'hF1, 6'h2A, 0);
    frame16(8'h5A, 6'h01, 1);
    frame16(8'hC7, 6'h3E, 3);
    frame16(8'h00, 6'h3F, 2);

    // R9 short and long frames discarded
    xfer(8, 64'hA7, rx, 0);
    expect_unchanged("R9 short frame");
    xfer(17, 64'h1FFFF, rx, 0);
    expect_unchanged("R9 long frame");
    frame16(8'h77, 6'h0B, 1);   // pointer still 2 from the last accepted frame

    // R10 daisy chain pass-through
    expw = diag[e_ptr*16 +: 16];
    xfer(32, {32'h0, 16'hD2B4, 16'h6E19}, rx, 0);
    chk(rx[31:16] === expw, "R10 chain status", rx[31:16], expw);
    chk(rx[15:0] === 16'hD2B4, "R10 chain passthrough", rx[15:0], 16'hD2B4);
    expect_unchanged("R9 chain frame discarded");

    // R3 snapshot ignores later diagnostic changes
    expw = diag[e_ptr*16 +: 16];
    xfer(16, {48'h0, 8'h9D, 6'h22, 2'd3}, rx, 1);
    chk(rx[15:0] === expw, "R3 snapshot held", rx[15:0], expw);
    e_ctrl[3] = 8'h9D; e_com = 6'h22; e_ptr = 3;
    expect_unchanged("R6 after snapshot frame");
    frame16(8'h12, 6'h05, 0);   // R3 new diagnostic value seen at next select

    // R1 reset clears everything again
    @(negedge clk) rst_n = 0;
    @(negedge clk);
    chk(ctrl_w === 0 && com_w === 0 && !oe_w, "R1 re-reset", {com_w, ctrl_w}, 0);
    rst_n = 1;
    for (int i = 0; i < 4; i++) e_ctrl[i] = 0;
    e_com = 0; e_ptr = 0;
    repeat (4) @(negedge clk);
    frame16(8'hAB, 6'h11, 3);   // R4 R5 R8 pointer back to 0

    done = 1;
    $display("  test done: total=%0d bad=%0d", tot, bad);
    $finish;
  end
endmodule